// File: doc/BRIEF.md
# Store-to-Load Forwarding Lookup Unit

This block holds a small circular queue of in-flight stores and answers forwarding lookups from a two-stage load pipeline. A load presents its virtual address, its physical address, a 16-bit byte-enable mask for a 128-bit data path, and a predecoded vector with one bit for each queue entry that is older than the load. In the first stage the unit returns a fast byte-hit mask and a fast data-not-ready flag. Both come from a search on the virtual address. On the following clock edge it registers the final result from the physical-address search: the byte-hit mask, the forwarded bytes, and three status causes. Those causes are data not ready, address not known, and a disagreement between the virtual and physical searches. The last one asks the surrounding logic to flush the store queue.

Stores enter at the tail pointer and leave at the head pointer. Their addresses and byte masks arrive on one write port and their data on another. The byte mask takes two clock edges to become visible to the search. Lookups have no back-pressure: the unit accepts a load in every cycle that `ld_valid` is high and always produces its stage-two result exactly one edge later. All other pins are plain control with no handshake.

Top module: `sq_forward_unit`

## Requirements
- R1: A stage-two hit bit for byte b is set only when some store qualifies. The store must be allocated, marked older in `ld_older`, and have a known address. Its physical address bits above bit 3 must equal the load's. Its byte-mask bit b must be set, and the load's mask bit b must be set too.
- R2: For each hit byte, `s2_data` carries that byte from the youngest qualifying store. Youngest is the last one reached when walking from `head_idx` forward in circular order. Bytes without a hit read zero.
- R3: Entries whose bit in `ld_older` is clear have no effect on any output, even when they are allocated and match.
- R4: `fast_hit_mask` is combinational in the same cycle as the load. It applies the R1 rule using virtual addresses and is zero when `ld_valid` is low.
- R5: `s2_valid` is `ld_valid` delayed by one clock edge. When `s2_valid` is low, every stage-two hit, data and status output is zero.
- R6: A qualifying older store with known address that overlaps the load, but whose data has not been written, raises a replay. `fast_data_inv` reports it in stage one from the virtual search. `s2_data_inv` reports it in stage two from the physical search, and `s2_data_inv_idx` gives the youngest such entry.
- R7: An allocated older entry whose address is not yet known raises `s2_addr_inv`, and `s2_addr_inv_idx` gives the youngest such entry.
- R8: `s2_match_inv` is set when, for any entry and byte, the virtual and physical searches disagree on a hit.
- R9: An address write on edge N becomes searchable only from edge N+1. Loads presented between the two edges see the entry as address-unknown.
- R10: `alloc_en` claims the entry at `tail_idx` and clears its address-known and data-known state. `free_en` releases the entry at `head_idx`. Both pointers advance by one per use and wrap modulo 8.
- R11: After reset, no entry is allocated, both pointers are 0 and `s2_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_en | input | 1 | Allocate the entry at the tail |
| free_en | input | 1 | Release the entry at the head |
| head_idx | output | 3 | Oldest entry index |
| tail_idx | output | 3 | Next entry to allocate |
| sa_en | input | 1 | Store address/mask write strobe |
| sa_idx | input | 3 | Entry written by the address port |
| sa_vaddr | input | 39 | Store virtual address |
| sa_paddr | input | 36 | Store physical address |
| sa_mask | input | 16 | Store byte mask |
| sd_en | input | 1 | Store data write strobe |
| sd_idx | input | 3 | Entry written by the data port |
| sd_data | input | 128 | Store data, byte lanes |
| ld_valid | input | 1 | Load lookup present this cycle |
| ld_vaddr | input | 39 | Load virtual address |
| ld_paddr | input | 36 | Load physical address |
| ld_mask | input | 16 | Load byte mask |
| ld_older | input | 8 | One bit per entry older than the load |
| fast_hit_mask | output | 16 | Stage-one byte hits (virtual search) |
| fast_data_inv | output | 1 | Stage-one data-not-ready flag |
| s2_valid | output | 1 | Stage-two result present |
| s2_hit_mask | output | 16 | Stage-two byte hits |
| s2_data | output | 128 | Forwarded bytes |
| s2_data_inv | output | 1 | Data-not-ready replay cause |
| s2_data_inv_idx | output | 3 | Entry causing data-not-ready |
| s2_addr_inv | output | 1 | Address-unknown replay cause |
| s2_addr_inv_idx | output | 3 | Entry causing address-unknown |
| s2_match_inv | output | 1 | Virtual/physical mismatch, flush request |

## Verification
The search is exercised with stores on the load's line and on a different line. It uses full, partial and disjoint byte masks, which separate the line compare from the byte-lane AND. Overlapping stores, tried under varied older-entry vectors and again after the pointers wrap past entry 7, show that the youngest writer wins in circular order rather than by raw index. Loads issued while a store's data is missing, in the cycle right after its address write, and against a store whose virtual and physical lines disagree show that each status cause and its index fire alone.

// File: rtl/sqfwd_pkg.sv
package sqfwd_pkg;
  localparam int SQ_DEPTH   = 8;
  localparam int LANE_BYTES = 16;
  localparam int VADDR_W    = 39;
  localparam int PADDR_W    = 36;
endpackage

// File: rtl/sqfwd_entries.sv
module sqfwd_entries #(
  parameter int DEPTH = sqfwd_pkg::SQ_DEPTH,
  parameter int BYTES = sqfwd_pkg::LANE_BYTES,
  parameter int VLW   = 35,
  parameter int PLW   = 32,
  localparam int IW   = $clog2(DEPTH),
  localparam int DW   = BYTES * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic             free_en,
  input  logic             sa_en,
  input  logic [IW-1:0]    sa_idx,
  input  logic [VLW-1:0]   sa_vline,
  input  logic [PLW-1:0]   sa_pline,
  input  logic [BYTES-1:0] sa_mask,
  input  logic             sd_en,
  input  logic [IW-1:0]    sd_idx,
  input  logic [DW-1:0]    sd_data,
  output logic [IW-1:0]    head,
  output logic [IW-1:0]    tail,
  output logic [DEPTH-1:0] ent_valid,
  output logic [DEPTH-1:0] ent_aok,
  output logic [DEPTH-1:0] ent_dok,
  output logic [VLW-1:0]   ent_vline [DEPTH],
  output logic [PLW-1:0]   ent_pline [DEPTH],
  output logic [BYTES-1:0] ent_mask  [DEPTH],
  output logic [DW-1:0]    ent_data  [DEPTH]
);
  // second cycle of the two-cycle mask write
  logic             pend_v;
  logic [IW-1:0]    pend_idx;
  logic [BYTES-1:0] pend_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head      <= '0;
      tail      <= '0;
      ent_valid <= '0;
      ent_aok   <= '0;
      ent_dok   <= '0;
      pend_v    <= 1'b0;
    end else begin
      pend_v <= sa_en;
      if (alloc_en) tail <= tail + IW'(1);
      if (free_en)  head <= head + IW'(1);
      for (int e = 0; e < DEPTH; e++) begin
        if (alloc_en && tail == IW'(e)) begin
          ent_valid[e] <= 1'b1;
          ent_aok[e]   <= 1'b0;
          ent_dok[e]   <= 1'b0;
        end
        if (free_en && head == IW'(e)) ent_valid[e] <= 1'b0;
        if (pend_v && pend_idx == IW'(e)) ent_aok[e] <= 1'b1;
        if (sd_en && sd_idx == IW'(e)) ent_dok[e] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (sa_en) begin
      pend_idx            <= sa_idx;
      pend_mask           <= sa_mask;
      ent_vline[sa_idx]   <= sa_vline;
      ent_pline[sa_idx]   <= sa_pline;
    end
    if (pend_v) ent_mask[pend_idx] <= pend_mask;
    if (sd_en)  ent_data[sd_idx]   <= sd_data;
  end
endmodule

// File: rtl/sqfwd_search.sv
module sqfwd_search #(
  parameter int DEPTH = sqfwd_pkg::SQ_DEPTH,
  parameter int BYTES = sqfwd_pkg::LANE_BYTES,
  parameter int LW    = 32
) (
  input  logic [LW-1:0]    ld_line,
  input  logic [BYTES-1:0] ld_mask,
  input  logic [DEPTH-1:0] cand,
  input  logic [LW-1:0]    ent_line [DEPTH],
  input  logic [BYTES-1:0] ent_mask [DEPTH],
  output logic [DEPTH-1:0] lane_hit [BYTES]
);
  logic [DEPTH-1:0] line_eq;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    assign line_eq[e] = cand[e] && (ent_line[e] == ld_line);
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    for (genvar e = 0; e < DEPTH; e++) begin : g_cell
      assign lane_hit[b][e] = line_eq[e] & ent_mask[e][b] & ld_mask[b];
    end
  end
endmodule

// File: rtl/sqfwd_youngest.sv
module sqfwd_youngest #(
  parameter int N  = sqfwd_pkg::SQ_DEPTH,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] base,
  output logic          found,
  output logic [IW-1:0] idx
);
  // walk from the oldest slot; the last requester seen is the youngest
  always_comb begin
    found = |req;
    idx   = base;
    for (int i = 0; i < N; i++) begin
      if (req[base + IW'(i)]) idx = base + IW'(i);
    end
  end
endmodule

// File: rtl/sq_forward_unit.sv
module sq_forward_unit #(
  parameter int DEPTH = sqfwd_pkg::SQ_DEPTH,
  parameter int BYTES = sqfwd_pkg::LANE_BYTES,
  parameter int VA_W  = sqfwd_pkg::VADDR_W,
  parameter int PA_W  = sqfwd_pkg::PADDR_W,
  localparam int IW   = $clog2(DEPTH),
  localparam int OFF  = $clog2(BYTES),
  localparam int DW   = BYTES * 8,
  localparam int VLW  = VA_W - OFF,
  localparam int PLW  = PA_W - OFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic             free_en,
  output logic [IW-1:0]    head_idx,
  output logic [IW-1:0]    tail_idx,
  input  logic             sa_en,
  input  logic [IW-1:0]    sa_idx,
  input  logic [VA_W-1:0]  sa_vaddr,
  input  logic [PA_W-1:0]  sa_paddr,
  input  logic [BYTES-1:0] sa_mask,
  input  logic             sd_en,
  input  logic [IW-1:0]    sd_idx,
  input  logic [DW-1:0]    sd_data,
  input  logic             ld_valid,
  input  logic [VA_W-1:0]  ld_vaddr,
  input  logic [PA_W-1:0]  ld_paddr,
  input  logic [BYTES-1:0] ld_mask,
  input  logic [DEPTH-1:0] ld_older,
  output logic [BYTES-1:0] fast_hit_mask,
  output logic             fast_data_inv,
  output logic             s2_valid,
  output logic [BYTES-1:0] s2_hit_mask,
  output logic [DW-1:0]    s2_data,
  output logic             s2_data_inv,
  output logic [IW-1:0]    s2_data_inv_idx,
  output logic             s2_addr_inv,
  output logic [IW-1:0]    s2_addr_inv_idx,
  output logic             s2_match_inv
);
  logic [DEPTH-1:0] ent_valid, ent_aok, ent_dok;
  logic [VLW-1:0]   ent_vline [DEPTH];
  logic [PLW-1:0]   ent_pline [DEPTH];
  logic [BYTES-1:0] ent_mask  [DEPTH];
  logic [DW-1:0]    ent_data  [DEPTH];

  logic offset_bits_unused;
  assign offset_bits_unused = ^{sa_vaddr[OFF-1:0], sa_paddr[OFF-1:0],
                                ld_vaddr[OFF-1:0], ld_paddr[OFF-1:0]};

  sqfwd_entries #(.DEPTH(DEPTH), .BYTES(BYTES), .VLW(VLW), .PLW(PLW)) u_entries (
    .clk, .rst_n, .alloc_en, .free_en,
    .sa_en, .sa_idx, .sa_vline(sa_vaddr[VA_W-1:OFF]), .sa_pline(sa_paddr[PA_W-1:OFF]),
    .sa_mask, .sd_en, .sd_idx, .sd_data,
    .head(head_idx), .tail(tail_idx),
    .ent_valid, .ent_aok, .ent_dok, .ent_vline, .ent_pline, .ent_mask, .ent_data
  );

  logic [DEPTH-1:0] cand, addr_pend;
  assign cand      = ld_older & ent_valid & ent_aok;
  assign addr_pend = ld_older & ent_valid & ~ent_aok;

  logic [DEPTH-1:0] v_lane [BYTES];
  logic [DEPTH-1:0] p_lane [BYTES];

  sqfwd_search #(.DEPTH(DEPTH), .BYTES(BYTES), .LW(VLW)) u_vsearch (
    .ld_line(ld_vaddr[VA_W-1:OFF]), .ld_mask, .cand,
    .ent_line(ent_vline), .ent_mask, .lane_hit(v_lane)
  );
  sqfwd_search #(.DEPTH(DEPTH), .BYTES(BYTES), .LW(PLW)) u_psearch (
    .ld_line(ld_paddr[PA_W-1:OFF]), .ld_mask, .cand,
    .ent_line(ent_pline), .ent_mask, .lane_hit(p_lane)
  );

  logic [BYTES-1:0] v_any, p_any;
  logic [IW-1:0]    sel [BYTES];
  logic [DW-1:0]    fwd_data;

  for (genvar b = 0; b < BYTES; b++) begin : g_pick
    assign v_any[b] = |v_lane[b];
    sqfwd_youngest #(.N(DEPTH)) u_lane_pick (
      .req(p_lane[b]), .base(head_idx), .found(p_any[b]), .idx(sel[b])
    );
    assign fwd_data[b*8 +: 8] = p_any[b] ? ent_data[sel[b]][b*8 +: 8] : 8'h00;
  end

  logic [DEPTH-1:0] v_ent, p_ent;
  logic             mism;
  always_comb begin
    v_ent = '0;
    p_ent = '0;
    mism  = 1'b0;
    for (int b = 0; b < BYTES; b++) begin
      v_ent = v_ent | v_lane[b];
      p_ent = p_ent | p_lane[b];
      mism  = mism | (|(v_lane[b] ^ p_lane[b]));
    end
  end

  logic          dmiss_any, apend_any;
  logic [IW-1:0] dmiss_idx, apend_idx;

  sqfwd_youngest #(.N(DEPTH)) u_dmiss_pick (
    .req(p_ent & ~ent_dok), .base(head_idx), .found(dmiss_any), .idx(dmiss_idx)
  );
  sqfwd_youngest #(.N(DEPTH)) u_apend_pick (
    .req(addr_pend), .base(head_idx), .found(apend_any), .idx(apend_idx)
  );

  assign fast_hit_mask = ld_valid ? v_any : '0;
  assign fast_data_inv = ld_valid && (|(v_ent & ~ent_dok));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_valid        <= 1'b0;
      s2_hit_mask     <= '0;
      s2_data         <= '0;
      s2_data_inv     <= 1'b0;
      s2_data_inv_idx <= '0;
      s2_addr_inv     <= 1'b0;
      s2_addr_inv_idx <= '0;
      s2_match_inv    <= 1'b0;
    end else begin
      s2_valid        <= ld_valid;
      s2_hit_mask     <= ld_valid ? p_any : '0;
      s2_data         <= ld_valid ? fwd_data : '0;
      s2_data_inv     <= ld_valid && dmiss_any;
      s2_data_inv_idx <= ld_valid ? dmiss_idx : '0;
      s2_addr_inv     <= ld_valid && apend_any;
      s2_addr_inv_idx <= ld_valid ? apend_idx : '0;
      s2_match_inv    <= ld_valid && mism;
    end
  end
endmodule

// File: rtl/sq_forward_unit_chk.sv
module sq_forward_unit_chk #(
  parameter int DEPTH = sqfwd_pkg::SQ_DEPTH,
  parameter int BYTES = sqfwd_pkg::LANE_BYTES,
  localparam int IW   = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_en,
  input logic             free_en,
  input logic [IW-1:0]    head_idx,
  input logic [IW-1:0]    tail_idx,
  input logic             ld_valid,
  input logic [BYTES-1:0] ld_mask,
  input logic [BYTES-1:0] fast_hit_mask,
  input logic             s2_valid,
  input logic [BYTES-1:0] s2_hit_mask,
  input logic             s2_data_inv,
  input logic             s2_addr_inv,
  input logic             s2_match_inv
);
  p_fast_in_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_hit_mask & ~ld_mask) == '0);

  p_fast_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |-> fast_hit_mask == '0);

  p_s2_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> s2_valid);

  p_s2_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> !s2_valid);

  p_s2_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_valid |-> (s2_hit_mask == '0 && !s2_data_inv && !s2_addr_inv && !s2_match_inv));

  p_s2_in_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> (s2_hit_mask & ~$past(ld_mask)) == '0);

  p_tail_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |=> (tail_idx - $past(tail_idx)) == IW'(1));

  p_head_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    free_en |=> (head_idx - $past(head_idx)) == IW'(1));

  p_head_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !free_en |=> $stable(head_idx));
endmodule

bind sq_forward_unit sq_forward_unit_chk #(.DEPTH(DEPTH), .BYTES(BYTES)) u_chk (.*);

// File: tb/test_sq_forward_unit.sv
module test_sq_forward_unit;
  localparam int N = 8;
  localparam int NB = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          alloc_en = 0, free_en = 0, sa_en = 0, sd_en = 0, ld_valid = 0;
  logic [2:0]    head_idx, tail_idx, sa_idx = 0, sd_idx = 0;
  logic [38:0]   sa_vaddr = 0, ld_vaddr = 0;
  logic [35:0]   sa_paddr = 0, ld_paddr = 0;
  logic [15:0]   sa_mask = 0, ld_mask = 0;
  logic [127:0]  sd_data = 0;
  logic [7:0]    ld_older = 0;
  logic [15:0]   fast_hit_mask, s2_hit_mask;
  logic          fast_data_inv, s2_valid, s2_data_inv, s2_addr_inv, s2_match_inv;
  logic [127:0]  s2_data;
  logic [2:0]    s2_data_inv_idx, s2_addr_inv_idx;

  sq_forward_unit i_sq_forward_unit (
    .clk, .rst_n, .alloc_en, .free_en, .head_idx, .tail_idx,
    .sa_en, .sa_idx, .sa_vaddr, .sa_paddr, .sa_mask,
    .sd_en, .sd_idx, .sd_data,
    .ld_valid, .ld_vaddr, .ld_paddr, .ld_mask, .ld_older,
    .fast_hit_mask, .fast_data_inv, .s2_valid, .s2_hit_mask, .s2_data,
    .s2_data_inv, .s2_data_inv_idx, .s2_addr_inv, .s2_addr_inv_idx, .s2_match_inv
  );

  int n_chk = 0, n_err = 0;

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference queue state
  bit          mv[N], maok[N], mdok[N];
  logic [34:0] mvl[N];
  logic [31:0] mpl[N];
  logic [15:0] mmask[N];
  logic [127:0] mdat[N];
  int mh = 0, mt = 0;

  // expected results
  logic [15:0]  e_fast, e_hit;
  logic [127:0] e_data;
  bit           e_fdinv, e_dinv, e_ainv, e_minv;
  logic [2:0]   e_didx, e_aidx;

  localparam logic [38:0] VA0 = 39'h12_3456_7000;
  localparam logic [35:0] PA0 = 36'h8_9ABC_D000;

  function automatic logic [127:0] mkdata(int tag);
    logic [127:0] d;
    for (int b = 0; b < NB; b++) d[b*8 +: 8] = 8'(tag * 16 + b);
    return d;
  endfunction

  // all tasks start and end just after a falling edge
  task automatic do_alloc();
    alloc_en = 1; @(negedge clk); alloc_en = 0;
    mv[mt] = 1; maok[mt] = 0; mdok[mt] = 0; mt = (mt + 1) % N;
  endtask

  task automatic do_free();
    free_en = 1; @(negedge clk); free_en = 0;
    mv[mh] = 0; mh = (mh + 1) % N;
  endtask

  task automatic do_addr(int e, int vl, int pl, logic [15:0] m, bit settle);
    sa_en = 1; sa_idx = 3'(e);
    sa_vaddr = VA0 + 39'(vl * 16); sa_paddr = PA0 + 36'(pl * 16); sa_mask = m;
    @(negedge clk); sa_en = 0;
    mvl[e] = sa_vaddr[38:4]; mpl[e] = sa_paddr[35:4]; mmask[e] = m;
    if (settle) begin @(negedge clk); maok[e] = 1; end
  endtask

  task automatic do_data(int e);
    sd_en = 1; sd_idx = 3'(e); sd_data = mkdata(e + 1);
    @(negedge clk); sd_en = 0;
    mdat[e] = mkdata(e + 1); mdok[e] = 1;
  endtask

  task automatic calc(logic [7:0] older, logic [38:0] va, logic [35:0] pa, logic [15:0] lm);
    e_fast = 0; e_hit = 0; e_data = 0;
    e_fdinv = 0; e_dinv = 0; e_ainv = 0; e_minv = 0; e_didx = 0; e_aidx = 0;
    for (int k = 0; k < N; k++) begin
      int e;
      logic [15:0] vb, pb;
      e = (mh + k) % N;
      if (older[e] && mv[e]) begin
        if (!maok[e]) begin
          e_ainv = 1; e_aidx = 3'(e);
        end else begin
          vb = (mvl[e] == va[38:4]) ? (mmask[e] & lm) : 16'h0;
          pb = (mpl[e] == pa[35:4]) ? (mmask[e] & lm) : 16'h0;
          if (vb != pb) e_minv = 1;
          e_fast |= vb;
          if (vb != 0 && !mdok[e]) e_fdinv = 1;
          if (pb != 0 && !mdok[e]) begin e_dinv = 1; e_didx = 3'(e); end
          for (int b = 0; b < NB; b++)
            if (pb[b]) begin e_hit[b] = 1; e_data[b*8 +: 8] = mdat[e][b*8 +: 8]; end
        end
      end
    end
  endtask

  task automatic query(string tag, logic [7:0] older, int vl, int pl, logic [15:0] lm);
    ld_valid = 1; ld_older = older; ld_mask = lm;
    ld_vaddr = VA0 + 39'(vl * 16) + 39'(3); ld_paddr = PA0 + 36'(pl * 16) + 36'(3);
    calc(older, ld_vaddr, ld_paddr, lm);
    #1;
    chk({"R4 fast hit ", tag}, 128'(fast_hit_mask), 128'(e_fast));
    chk({"R6 fast data-inv ", tag}, 128'(fast_data_inv), 128'(e_fdinv));
    @(negedge clk); ld_valid = 0; #1;
    chk({"R5 s2 valid ", tag}, 128'(s2_valid), 128'(1));
    chk({"R1 hit mask ", tag}, 128'(s2_hit_mask), 128'(e_hit));
    if (!e_dinv) chk({"R2 data ", tag}, s2_data, e_data);
    chk({"R6 data-inv ", tag}, 128'(s2_data_inv), 128'(e_dinv));
    if (e_dinv) chk({"R6 data-inv idx ", tag}, 128'(s2_data_inv_idx), 128'(e_didx));
    chk({"R7 addr-inv ", tag}, 128'(s2_addr_inv), 128'(e_ainv));
    if (e_ainv) chk({"R7 addr-inv idx ", tag}, 128'(s2_addr_inv_idx), 128'(e_aidx));
    chk({"R8 match-inv ", tag}, 128'(s2_match_inv), 128'(e_minv));
  endtask

  task automatic t_reset();
    chk("R11 head", 128'(head_idx), 128'(0));
    chk("R11 tail", 128'(tail_idx), 128'(0));
    chk("R11 s2_valid", 128'(s2_valid), 128'(0));
    query("R11 empty queue", 8'hFF, 0, 0, 16'hFFFF);
    chk("R11 no hit on empty", 128'(e_hit), 128'(0));
  endtask

  task automatic t_basic();
    do_alloc(); do_alloc(); do_alloc();
    chk("R10 tail after 3 allocs", 128'(tail_idx), 128'(3));
    do_addr(0, 0, 0, 16'h00FF, 1); do_data(0);
    do_addr(1, 1, 1, 16'hFFFF, 1); do_data(1);
    do_addr(2, 0, 0, 16'h0F00, 1); do_data(2);
    query("R1 same line full mask", 8'h07, 0, 0, 16'hFFFF);
    chk("R1 expected lanes", 128'(s2_hit_mask), 128'(16'h0FFF));
    query("R1 other store line", 8'h07, 1, 1, 16'h00F0);
    query("R1 unmatched line", 8'h07, 2, 2, 16'hFFFF);
    chk("R1 no hit other line", 128'(s2_hit_mask), 128'(0));
    query("R1 disjoint load mask", 8'h07, 0, 0, 16'hF000);
    @(negedge clk); #1;
    chk("R5 idle s2_valid", 128'(s2_valid), 128'(0));
    chk("R5 idle hit mask", 128'(s2_hit_mask), 128'(0));
  endtask

  task automatic t_youngest();
    do_alloc(); do_addr(3, 0, 0, 16'h00F0, 1); do_data(3);
    query("R2 youngest overlap", 8'h0F, 0, 0, 16'hFFFF);
    chk("R2 byte4 from entry3", 128'(s2_data[39:32]), 128'(8'h44));
    query("R3 younger excluded", 8'h07, 0, 0, 16'hFFFF);
    chk("R3 byte4 from entry0", 128'(s2_data[39:32]), 128'(8'h14));
    query("R3 nothing older", 8'h00, 0, 0, 16'hFFFF);
  endtask

  task automatic t_data_wait();
    do_alloc(); do_addr(4, 0, 0, 16'h0003, 1);
    query("R6 data missing", 8'h1F, 0, 0, 16'hFFFF);
    chk("R6 flag raised", 128'(s2_data_inv), 128'(1));
    do_data(4);
    query("R6 data arrived", 8'h1F, 0, 0, 16'hFFFF);
  endtask

  task automatic t_addr_wait();
    do_alloc(); do_data(5);
    query("R7 address unknown", 8'h3F, 0, 0, 16'hFFFF);
    do_addr(5, 0, 0, 16'hC000, 0);
    query("R9 mask write in flight", 8'h3F, 0, 0, 16'hFFFF);
    chk("R9 still unknown", 128'(s2_addr_inv), 128'(1));
    maok[5] = 1;
    query("R9 mask visible", 8'h3F, 0, 0, 16'hFFFF);
    chk("R9 lanes 14-15", 128'(s2_hit_mask[15:14]), 128'(2'b11));
  endtask

  task automatic t_mismatch();
    do_alloc(); do_addr(6, 0, 3, 16'h3000, 1); do_data(6);
    query("R8 vaddr hits paddr misses", 8'h7F, 0, 0, 16'hFFFF);
    chk("R8 flush raised", 128'(s2_match_inv), 128'(1));
    query("R8 agree on other line", 8'h7F, 9, 9, 16'hFFFF);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 7; i++) do_free();
    chk("R10 head after frees", 128'(head_idx), 128'(7));
    do_alloc(); do_alloc(); do_alloc();
    chk("R10 tail wrapped", 128'(tail_idx), 128'(2));
    do_addr(7, 0, 0, 16'hFFFF, 1); do_data(7);
    do_addr(0, 0, 0, 16'h00FF, 1); do_data(0);
    do_addr(1, 0, 0, 16'h0F00, 1); do_data(1);
    query("R2 wrap three writers", 8'h83, 0, 0, 16'hFFFF);
    chk("R2 byte0 from entry0", 128'(s2_data[7:0]), 128'(8'h10));
    chk("R2 byte15 from entry7", 128'(s2_data[127:120]), 128'(8'h8F));
    query("R2 wrap oldest only", 8'h80, 0, 0, 16'hFFFF);
    query("R3 wrap two older", 8'h81, 0, 0, 16'h0FF0);
  endtask

  initial begin
    #(8 * 200000);
    n_err++; n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    t_reset();
    t_basic();
    t_youngest();
    t_data_wait();
    t_addr_wait();
    t_mismatch();
    t_wrap();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule